// File: doc/BRIEF.md
# Flagless Skip-Condition Evaluator

This block decides whether a processor without condition flags and without a compare instruction should nullify the instruction that follows the current one. For each instruction presented with `in_valid`, it reads a condition selector, two register operands, a bit index and the raw carry-out of the adder. It then produces a registered skip decision together with a one-cycle valid strobe. No flag state is written anywhere: every condition is derived directly from the operands.

Single-register tests cover one selected bit, zero or non-zero, and the sign, including the combined sign-and-zero forms. Register-register tests cover equality and all four unsigned and all four signed orderings. The signed orderings are formed by an unsigned comparison after the top bit of each operand is inverted, so no subtraction that could overflow is involved. Two further selector codes let an add or a subtract with its skip bit set request a skip when no carry or no borrow occurred. The instruction that a skip nullifies can never raise a skip of its own.

Top module: `skip_eval`

## Requirements
- R1: Selector 0 (bit set) skips when `op_a[bit_idx]` is 1, and selector 1 (bit clear) skips when `op_a[bit_idx]` is 0.
- R2: Selector 2 (zero) skips when all 32 bits of `op_a` are 0, and selector 3 (non-zero) skips when any bit of `op_a` is 1.
- R3: Selector 4 (plus) skips when `op_a[31]` is 0, and selector 5 (minus) skips when `op_a[31]` is 1.
- R4: Selector 6 skips when `op_a[31]` is 0 and `op_a` is non-zero. Selector 7 skips when `op_a[31]` is 1 or `op_a` is zero.
- R5: Selector 8 skips when `op_a` equals `op_b`, and selector 9 skips when they differ. The same register on both operands gives an always-skip with 8 and a never-skip with 9.
- R6: Unsigned selectors skip as follows: 10 when a > b, 11 when a >= b, 12 when a <= b and 13 when a < b, for every operand pair.
- R7: Signed (two's complement) selectors skip as follows: 14 when a > b, 15 when a >= b, 16 when a <= b and 17 when a < b. The results are correct for every operand pair, including the most negative and most positive values.
- R8: Selector 18 (add with skip) skips when `carry` is 0. Selector 19 (subtract with skip, where borrow is the inverse of the adder carry-out) skips when `carry` is 1, that is, when no borrow occurred.
- R9: Selector codes 20 to 31 never skip.
- R10: After an `in_valid` cycle, `skip_vld` is 1 for exactly the following cycle, with the decision on `skip_q`. `skip_vld` is 0 after any cycle without `in_valid`, and `skip_q` is 1 only while `skip_vld` is 1.
- R11: The next valid instruction after one whose decision was a skip is the nullified one. Its decision is forced to 0, and the valid instruction after it is evaluated normally.
- R12: While `rst_n` is 0, `skip_vld` and `skip_q` are 0, and any pending nullification is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented for evaluation this cycle |
| cond_sel | input | 5 | Condition selector code |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| bit_idx | input | 5 | Bit position for the bit tests |
| carry | input | 1 | Raw carry-out of the adder for the current add or subtract |
| skip_vld | output | 1 | Decision strobe, one cycle after `in_valid` |
| skip_q | output | 1 | Skip the next instruction |

## Verification
The checker assumes that the inputs are meaningful only in cycles where `in_valid` is high. It also assumes that the nullification state it models is fully determined by the decisions seen on `skip_q` since reset. For that reason, its relational checks take the pending-nullification flag from the observed outputs and not from the design's internals. The stimulus presents one instruction per valid cycle, with operands held stable around the sampling edge. It also includes a back-to-back sequence and a reset taken while a nullification is pending. After each test that ends in a skip, it inserts a never-skip filler so that the next test starts from a clean state.

// File: rtl/skip_eval.sv
module skip_eval #(
  parameter int W = 32,
  parameter int SELW = 5,
  localparam int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SELW-1:0] cond_sel,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            carry,
  output logic            skip_vld,
  output logic            skip_q
);

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic sel_bit, a_zero, a_neg, eq, ugt, sgt, raw;
  logic shadow;

  assign sel_bit = op_a[bit_idx];
  assign a_zero  = (op_a == '0);
  assign a_neg   = op_a[W-1];
  assign eq      = (op_a == op_b);
  assign ugt     = (op_a > op_b);
  assign sgt     = ((op_a ^ MSB) > (op_b ^ MSB));

  always_comb begin
    case (cond_sel)
      5'd0:    raw = sel_bit;
      5'd1:    raw = !sel_bit;
      5'd2:    raw = a_zero;
      5'd3:    raw = !a_zero;
      5'd4:    raw = !a_neg;
      5'd5:    raw = a_neg;
      5'd6:    raw = !a_neg && !a_zero;
      5'd7:    raw = a_neg || a_zero;
      5'd8:    raw = eq;
      5'd9:    raw = !eq;
      5'd10:   raw = ugt;
      5'd11:   raw = ugt || eq;
      5'd12:   raw = !ugt;
      5'd13:   raw = !ugt && !eq;
      5'd14:   raw = sgt;
      5'd15:   raw = sgt || eq;
      5'd16:   raw = !sgt;
      5'd17:   raw = !sgt && !eq;
      5'd18:   raw = !carry;
      5'd19:   raw = carry;
      default: raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_vld <= 1'b0;
      skip_q   <= 1'b0;
      shadow   <= 1'b0;
    end else begin
      skip_vld <= in_valid;
      skip_q   <= in_valid && !shadow && raw;
      if (in_valid) shadow <= !shadow && raw;
    end
  end

endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  cond_sel,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        skip_vld,
  input logic        skip_q
);

  logic pend, pend_now;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_now;
  end
  assign pend_now = skip_vld ? skip_q : pend;

  AST_VLD_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> skip_vld); // R10
  AST_VLD_ONLY_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !skip_vld); // R10
  AST_SKIP_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n) skip_q |-> skip_vld); // R10
  AST_NO_CHAINED_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (skip_q && pend) == 1'b0); // R11
  AST_EQ_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 5'd8 && op_a == op_b && !pend_now) |=> skip_q); // R5
  AST_SIGNED_LT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 5'd17 && !pend_now) |=> (skip_q == ($signed(op_a) < $signed(op_b)))); // R7
  AST_UNSIGNED_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 5'd13 && !pend_now) |=> (skip_q == (op_a < op_b))); // R6
  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel >= 5'd20) |=> !skip_q); // R9
  always_comb if (!rst_n) AST_RESET_QUIET: assert (!skip_vld && !skip_q); // R12

endmodule

bind skip_eval skip_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
  .op_a(op_a), .op_b(op_b), .skip_vld(skip_vld), .skip_q(skip_q)
);

// File: tb/sim_skip_eval.sv
`timescale 1ns/1ps
module sim_skip_eval;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] cond_sel = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [4:0] bit_idx = '0;
  logic carry = 1'b0;
  logic skip_vld, skip_q;

  int total = 0, bad = 0;
  bit pend = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  skip_eval u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
    .op_a(op_a), .op_b(op_b), .bit_idx(bit_idx), .carry(carry),
    .skip_vld(skip_vld), .skip_q(skip_q)
  );

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic issue_raw(input logic [4:0] s, input logic [31:0] a, input logic [31:0] b,
                           input logic [4:0] ix, input logic c, input bit raw, input string rq);
    bit exp;
    @(negedge clk);
    cond_sel = s; op_a = a; op_b = b; bit_idx = ix; carry = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = pend ? 1'b0 : raw;
    pend = exp;
    check(skip_vld == 1'b1, "R10", "skip_vld after valid", int'(skip_vld), 1);
    check(skip_q == exp, rq, $sformatf("skip_q sel=%0d", s), int'(skip_q), int'(exp));
    @(negedge clk);
    check(!skip_vld && !skip_q, "R10", "strobe width", int'({skip_vld, skip_q}), 0);
  endtask

  task automatic issue(input logic [4:0] s, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] ix, input logic c, input bit raw, input string rq);
    issue_raw(s, a, b, ix, c, raw, rq);
    if (pend) issue_raw(5'd9, 32'd0, 32'd0, 5'd0, 1'b0, 1'b0, "R11");
  endtask

  task automatic t_reset;
    check(!skip_vld && !skip_q, "R12", "outputs in reset", int'({skip_vld, skip_q}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!skip_vld && !skip_q, "R12", "outputs after reset", int'({skip_vld, skip_q}), 0);
  endtask

  task automatic t_bits;
    issue(5'd0, 32'h8000_0000, 0, 5'd31, 0, 1, "R1");
    issue(5'd0, 32'h8000_0000, 0, 5'd30, 0, 0, "R1");
    issue(5'd1, 32'hFFFF_FFFE, 0, 5'd0, 0, 1, "R1");
    issue(5'd0, 32'hFFFF_FFFE, 0, 5'd0, 0, 0, "R1");
    issue(5'd1, 32'h0000_0400, 0, 5'd10, 0, 0, "R1");
  endtask

  task automatic t_zero_sign;
    issue(5'd2, 32'h0, 0, 0, 0, 1, "R2");
    issue(5'd2, 32'h1, 0, 0, 0, 0, "R2");
    issue(5'd3, 32'h0, 0, 0, 0, 0, "R2");
    issue(5'd3, 32'h100, 0, 0, 0, 1, "R2");
    issue(5'd4, 32'h7FFF_FFFF, 0, 0, 0, 1, "R3");
    issue(5'd4, 32'h8000_0000, 0, 0, 0, 0, "R3");
    issue(5'd5, 32'h8000_0000, 0, 0, 0, 1, "R3");
    issue(5'd5, 32'h0, 0, 0, 0, 0, "R3");
    issue(5'd6, 32'h0, 0, 0, 0, 0, "R4");
    issue(5'd6, 32'h5, 0, 0, 0, 1, "R4");
    issue(5'd6, 32'h8000_0001, 0, 0, 0, 0, "R4");
    issue(5'd7, 32'h0, 0, 0, 0, 1, "R4");
    issue(5'd7, 32'h8000_0000, 0, 0, 0, 1, "R4");
    issue(5'd7, 32'h5, 0, 0, 0, 0, "R4");
  endtask

  task automatic t_equal;
    issue(5'd8, 32'd3, 32'd4, 0, 0, 0, "R5");
    issue(5'd9, 32'd3, 32'd4, 0, 0, 1, "R5");
    issue(5'd8, 32'd0, 32'd0, 0, 0, 1, "R5");
    issue(5'd9, 32'd9, 32'd9, 0, 0, 0, "R5");
  endtask

  task automatic t_unsigned;
    issue(5'd10, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, "R6");
    issue(5'd13, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R6");
    issue(5'd10, 32'd7, 32'd7, 0, 0, 0, "R6");
    issue(5'd11, 32'd7, 32'd7, 0, 0, 1, "R6");
    issue(5'd12, 32'd7, 32'd7, 0, 0, 1, "R6");
    issue(5'd13, 32'd0, 32'hFFFF_FFFF, 0, 0, 1, "R6");
    issue(5'd12, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, "R6");
  endtask

  task automatic t_signed;
    issue(5'd14, 32'd1, 32'hFFFF_FFFF, 0, 0, 1, "R7");
    issue(5'd17, 32'd1, 32'hFFFF_FFFF, 0, 0, 0, "R7");
    issue(5'd17, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 1, "R7");
    issue(5'd15, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 1, "R7");
    issue(5'd15, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, "R7");
    issue(5'd16, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 0, 0, 1, "R7");
    issue(5'd14, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 0, 0, 0, "R7");
    issue(5'd16, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0, "R7");
  endtask

  task automatic t_arith;
    issue(5'd18, 0, 0, 0, 1'b0, 1, "R8");
    issue(5'd18, 0, 0, 0, 1'b1, 0, "R8");
    issue(5'd19, 0, 0, 0, 1'b1, 1, "R8");
    issue(5'd19, 0, 0, 0, 1'b0, 0, "R8");
  endtask

  task automatic t_unused;
    issue(5'd20, 0, 0, 0, 0, 0, "R9");
    issue(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 0, 0, "R9");
    issue(5'd25, 0, 32'd1, 0, 0, 0, "R9");
  endtask

  task automatic t_shadow;
    issue_raw(5'd8, 32'd5, 32'd5, 0, 0, 1, "R11");
    issue_raw(5'd8, 32'd7, 32'd7, 0, 0, 1, "R11");
    issue_raw(5'd8, 32'd7, 32'd7, 0, 0, 1, "R11");
    if (pend) issue_raw(5'd9, 0, 0, 0, 0, 0, "R11");
  endtask

  task automatic t_back2back;
    @(negedge clk);
    cond_sel = 5'd10; op_a = 32'd2; op_b = 32'd1; in_valid = 1'b1;
    @(negedge clk);
    check(skip_vld && skip_q, "R10", "first of pair", int'({skip_vld, skip_q}), 3);
    op_a = 32'd3;
    @(negedge clk);
    in_valid = 1'b0;
    check(skip_vld && !skip_q, "R11", "shadowed second of pair", int'({skip_vld, skip_q}), 2);
    @(negedge clk);
    check(!skip_vld && !skip_q, "R10", "idle after pair", int'({skip_vld, skip_q}), 0);
    pend = 1'b0;
  endtask

  task automatic t_reset_clears;
    issue_raw(5'd8, 32'd1, 32'd1, 0, 0, 1, "R12");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(!skip_vld && !skip_q, "R12", "outputs in mid-run reset", int'({skip_vld, skip_q}), 0);
    rst_n = 1'b1;
    pend = 1'b0;
    issue_raw(5'd8, 32'd1, 32'd1, 0, 0, 1, "R12");
    if (pend) issue_raw(5'd9, 0, 0, 0, 0, 0, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_bits;
    t_zero_sign;
    t_equal;
    t_unsigned;
    t_signed;
    t_arith;
    t_unused;
    t_shadow;
    t_back2back;
    t_reset_clears;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule